// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside a data cache and tracks the one line reservation that load-linked and store-conditional pairs depend on. The cache controller reports each finished access as a completion event. The event carries a line address, an access kind and the identifier of the requester that issued it. The monitor keeps a single held reservation, made of a valid bit, a line address and an owner identifier. Each completion updates that reservation, and the monitor reports a result bit for the access. A store-conditional reports 1 when it succeeds and 0 when it fails. Every other access kind reports 1.

A separate drop input carries a line address. The cache raises it when a line loses permission, whether through an invalidation or an eviction. A drop that matches the held line removes the reservation. A drop in the same cycle as a completion is applied first, so a store-conditional to a dropped line always fails. The held reservation is visible on output ports, so the core, or a test, can observe it directly.

Top module: `llsc_resv_monitor`

## Requirements
- R1: After reset, no reservation is held (`hold_valid` is 0) and `result_valid` is 0.
- R2: Access kinds are encoded on `done_kind` as 0 load, 1 instruction fetch, 2 store, 3 read-modify-write read, 4 read-modify-write write, 5 load-linked, 6 store-conditional, and 7 reserved. Kinds 0, 1 and 7 form the read class. A read-class completion reports 1 and leaves the reservation unchanged.
- R3: A load-linked completion reports 1. It installs a reservation on its line, tagged with its requester identifier, and this replaces any earlier reservation.
- R4: A store-conditional reports 1 only if the held reservation is valid, is on the same line and belongs to the same requester. Otherwise it reports 0.
- R5: A store-conditional removes a reservation held on its line, whether it succeeds or fails and whoever owns that reservation. A store-conditional to a different line leaves the reservation in place.
- R6: A store or read-modify-write completion (kinds 2, 3 and 4) reports 1. It removes the reservation only when that reservation is on the same line and owned by the same requester.
- R7: A drop whose line equals the held line removes the reservation. A drop on any other line has no effect.
- R8: When a drop and a store-conditional name the same line in one cycle, the store-conditional reports 0.
- R9: When a drop and a load-linked name the same line in one cycle, the load-linked reports 1 but no reservation is installed for that line.
- R10: `result_valid` and `result_ok` appear exactly one clock after the completion. The reservation ports show the state after a cycle's events one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_valid | input | 1 | A completion event is present this cycle |
| done_line | input | LINE_W | Line address of the completed access |
| done_kind | input | 3 | Access kind (encoding in R2) |
| done_owner | input | ID_W | Identifier of the requester |
| drop_valid | input | 1 | A line has lost permission this cycle |
| drop_line | input | LINE_W | Line address that lost permission |
| result_valid | output | 1 | Result for the previous cycle's completion |
| result_ok | output | 1 | 1 = success, 0 = store-conditional failure |
| hold_valid | output | 1 | A reservation is held |
| hold_line | output | LINE_W | Line address of the held reservation |
| hold_owner | output | ID_W | Owner of the held reservation |

## Verification
Every result, and every change to the reservation, lands one register stage after the cycle in which its completion or drop is presented. The bench drives inputs on the falling edge. It lets one rising edge pass and then samples the result and the reservation ports on the next falling edge, before it drives anything new. The expected values come from a small reference model in the bench. That model applies the drop first and then the completion. Random events are kept to four lines and three owners so that matches and conflicts are frequent.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [2:0] {
        K_LOAD   = 3'd0,
        K_FETCH  = 3'd1,
        K_STORE  = 3'd2,
        K_RMW_RD = 3'd3,
        K_RMW_WR = 3'd4,
        K_LL     = 3'd5,
        K_SC     = 3'd6,
        K_RSVD   = 3'd7
    } kind_e;

    typedef struct packed {
        logic is_read;
        logic is_ll;
        logic is_sc;
        logic is_plain_wr;
    } kind_class_t;

endpackage

// File: rtl/llsc_kind_decode.sv
module llsc_kind_decode
    import llsc_pkg::*;
(
    input  logic [2:0]  kind,
    output kind_class_t cls
);
    always_comb begin
        cls = '0;
        unique case (kind_e'(kind))
            K_LL:                       cls.is_ll       = 1'b1;
            K_SC:                       cls.is_sc       = 1'b1;
            K_STORE, K_RMW_RD, K_RMW_WR: cls.is_plain_wr = 1'b1;
            default:                    cls.is_read     = 1'b1;
        endcase
    end
endmodule

// File: rtl/llsc_line_match.sv
module llsc_line_match #(
    parameter int LINE_W = 26,
    parameter int ID_W   = 4
) (
    input  logic              held_valid,
    input  logic [LINE_W-1:0] held_line,
    input  logic [ID_W-1:0]   held_owner,
    input  logic [LINE_W-1:0] probe_line,
    input  logic [ID_W-1:0]   probe_owner,
    output logic              line_hit,
    output logic              owner_hit
);
    always_comb begin
        line_hit  = held_valid && (held_line == probe_line);
        owner_hit = line_hit && (held_owner == probe_owner);
    end
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
    import llsc_pkg::*;
#(
    parameter int LINE_W = 26,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_valid,
    input  logic [LINE_W-1:0] done_line,
    input  logic [2:0]        done_kind,
    input  logic [ID_W-1:0]   done_owner,
    input  logic              drop_valid,
    input  logic [LINE_W-1:0] drop_line,
    output logic              result_valid,
    output logic              result_ok,
    output logic              hold_valid,
    output logic [LINE_W-1:0] hold_line,
    output logic [ID_W-1:0]   hold_owner
);
    localparam int STATE_W = 3 + LINE_W + ID_W;

    typedef struct packed {
        logic              rv;
        logic              rok;
        logic              hv;
        logic [LINE_W-1:0] hl;
        logic [ID_W-1:0]   ho;
    } state_t;

    state_t      st_q, st_d;
    kind_class_t cls;
    logic        drop_hit_held;
    logic        drop_owner_unused;
    logic        after_valid;
    logic        done_line_hit, done_owner_hit;
    logic        drop_on_done;

    llsc_kind_decode u_decode (
        .kind (done_kind),
        .cls  (cls)
    );

    // drop against the held reservation
    llsc_line_match #(.LINE_W(LINE_W), .ID_W(ID_W)) u_drop_match (
        .held_valid  (st_q.hv),
        .held_line   (st_q.hl),
        .held_owner  (st_q.ho),
        .probe_line  (drop_line),
        .probe_owner (st_q.ho),
        .line_hit    (drop_hit_held),
        .owner_hit   (drop_owner_unused)
    );

    // reservation as it stands once any drop has been applied
    assign after_valid = st_q.hv && !(drop_valid && drop_hit_held);

    // completion against the post-drop reservation
    llsc_line_match #(.LINE_W(LINE_W), .ID_W(ID_W)) u_done_match (
        .held_valid  (after_valid),
        .held_line   (st_q.hl),
        .held_owner  (st_q.ho),
        .probe_line  (done_line),
        .probe_owner (done_owner),
        .line_hit    (done_line_hit),
        .owner_hit   (done_owner_hit)
    );

    assign drop_on_done = drop_valid && (drop_line == done_line);

    always_comb begin
        st_d     = st_q;
        st_d.hv  = after_valid;
        st_d.rv  = done_valid;
        st_d.rok = 1'b0;
        if (done_valid) begin
            st_d.rok = 1'b1;
            if (cls.is_ll) begin
                if (!drop_on_done) begin
                    st_d.hv = 1'b1;
                    st_d.hl = done_line;
                    st_d.ho = done_owner;
                end
            end else if (cls.is_sc) begin
                st_d.rok = done_owner_hit;
                if (done_line_hit) st_d.hv = 1'b0;
            end else if (cls.is_plain_wr) begin
                if (done_owner_hit) st_d.hv = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= state_t'({STATE_W{1'b0}});
        end else begin
            st_q <= st_d;
        end
    end

    assign result_valid = st_q.rv;
    assign result_ok    = st_q.rok;
    assign hold_valid   = st_q.hv;
    assign hold_line    = st_q.hl;
    assign hold_owner   = st_q.ho;

endmodule

// File: rtl/llsc_resv_monitor_chk.sv
module llsc_resv_monitor_chk #(
    parameter int LINE_W = 26,
    parameter int ID_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_valid,
    input logic [LINE_W-1:0] done_line,
    input logic [2:0]        done_kind,
    input logic [ID_W-1:0]   done_owner,
    input logic              drop_valid,
    input logic [LINE_W-1:0] drop_line,
    input logic              result_valid,
    input logic              result_ok,
    input logic              hold_valid,
    input logic [LINE_W-1:0] hold_line,
    input logic [ID_W-1:0]   hold_owner
);
    logic is_read_k, drop_same, held_same, held_mine;
    assign is_read_k = (done_kind == 3'd0) || (done_kind == 3'd1) || (done_kind == 3'd7);
    assign drop_same = drop_valid && (drop_line == done_line);
    assign held_same = hold_valid && (hold_line == done_line);
    assign held_mine = held_same && (hold_owner == done_owner);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !hold_valid && !result_valid);

    assert_read_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && is_read_k && !drop_valid |=>
            result_ok && $stable(hold_valid) && $stable(hold_line) && $stable(hold_owner));

    assert_ll_installs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_kind == 3'd5 && !drop_same |=>
            result_ok && hold_valid && hold_line == $past(done_line) && hold_owner == $past(done_owner));

    assert_sc_needs_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_kind == 3'd6 && !held_mine |=> !result_ok);

    assert_sc_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_kind == 3'd6 && held_same |=> !hold_valid);

    assert_store_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && (done_kind == 3'd2 || done_kind == 3'd3 || done_kind == 3'd4) && held_mine
            |=> !hold_valid && result_ok);

    assert_drop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drop_valid && hold_valid && drop_line == hold_line && !(done_valid && done_kind == 3'd5)
            |=> !hold_valid);

    assert_drop_beats_sc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_kind == 3'd6 && drop_same |=> !result_ok);

    assert_result_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> result_valid);

    assert_no_spurious_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_valid |=> !result_valid);
endmodule

bind llsc_resv_monitor llsc_resv_monitor_chk #(.LINE_W(LINE_W), .ID_W(ID_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .done_valid   (done_valid),
    .done_line    (done_line),
    .done_kind    (done_kind),
    .done_owner   (done_owner),
    .drop_valid   (drop_valid),
    .drop_line    (drop_line),
    .result_valid (result_valid),
    .result_ok    (result_ok),
    .hold_valid   (hold_valid),
    .hold_line    (hold_line),
    .hold_owner   (hold_owner)
);

// File: tb/llsc_resv_monitor_test.sv
module llsc_resv_monitor_test;
    localparam int LW = 26;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          done_valid = 1'b0;
    logic [LW-1:0] done_line = '0;
    logic [2:0]    done_kind = '0;
    logic [IW-1:0] done_owner = '0;
    logic          drop_valid = 1'b0;
    logic [LW-1:0] drop_line = '0;
    logic          result_valid, result_ok, hold_valid;
    logic [LW-1:0] hold_line;
    logic [IW-1:0] hold_owner;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // reference model
    logic          m_v = 1'b0;
    logic [LW-1:0] m_l = '0;
    logic [IW-1:0] m_o = '0;

    always #2 clk = ~clk;

    llsc_resv_monitor #(.LINE_W(LW), .ID_W(IW)) uut (
        .clk(clk), .rst_n(rst_n),
        .done_valid(done_valid), .done_line(done_line), .done_kind(done_kind),
        .done_owner(done_owner), .drop_valid(drop_valid), .drop_line(drop_line),
        .result_valid(result_valid), .result_ok(result_ok),
        .hold_valid(hold_valid), .hold_line(hold_line), .hold_owner(hold_owner)
    );

    function automatic string req_of(logic dv, logic [2:0] k, logic pv);
        if (!dv) return pv ? "R7" : "R10";
        case (k)
            3'd5: return "R3";
            3'd6: return "R4";
            3'd2, 3'd3, 3'd4: return "R6";
            default: return "R2";
        endcase
    endfunction

    function automatic logic exp_ok(logic dv, logic [2:0] k, logic [LW-1:0] l,
                                    logic [IW-1:0] o, logic pv, logic [LW-1:0] pl);
        logic av;
        av = m_v && !(pv && pl == m_l);
        if (!dv) return 1'b0;
        if (k == 3'd6) return av && m_l == l && m_o == o;
        return 1'b1;
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply(logic dv, logic [2:0] k, logic [LW-1:0] l, logic [IW-1:0] o,
                         logic pv, logic [LW-1:0] pl);
        logic eok;
        string r;
        r = req_of(dv, k, pv);
        done_valid = dv; done_kind = k; done_line = l; done_owner = o;
        drop_valid = pv; drop_line = pl;
        eok = exp_ok(dv, k, l, o, pv, pl);
        // model update: drop first, then completion
        if (pv && m_v && pl == m_l) m_v = 1'b0;
        if (dv) begin
            if (k == 3'd5) begin
                if (!(pv && pl == l)) begin m_v = 1'b1; m_l = l; m_o = o; end
            end else if (k == 3'd6) begin
                if (m_v && m_l == l) m_v = 1'b0;
            end else if (k == 3'd2 || k == 3'd3 || k == 3'd4) begin
                if (m_v && m_l == l && m_o == o) m_v = 1'b0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check("R10", "result_valid", 64'(result_valid), 64'(dv));
        if (dv) check(r, "result_ok", 64'(result_ok), 64'(eok));
        check(r, "hold_valid", 64'(hold_valid), 64'(m_v));
        if (m_v) begin
            check(r, "hold_line", 64'(hold_line), 64'(m_l));
            check(r, "hold_owner", 64'(hold_owner), 64'(m_o));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "hold_valid after reset", 64'(hold_valid), 64'd0);
        check("R1", "result_valid after reset", 64'(result_valid), 64'd0);
        rst_n = 1'b1;

        // R3: LL installs; R4: SC by same owner succeeds; R5: reservation gone
        apply(1, 3'd5, 26'd8, 4'd1, 0, '0);
        apply(1, 3'd6, 26'd8, 4'd1, 0, '0);
        apply(1, 3'd6, 26'd8, 4'd1, 0, '0);   // R4 no reservation -> fail
        // R5: SC by other owner fails and still clears
        apply(1, 3'd5, 26'd8, 4'd1, 0, '0);
        apply(1, 3'd6, 26'd8, 4'd2, 0, '0);
        // R5: SC to another line leaves reservation
        apply(1, 3'd5, 26'd8, 4'd1, 0, '0);
        apply(1, 3'd6, 26'd9, 4'd1, 0, '0);
        // R3: replacement by new LL
        apply(1, 3'd5, 26'd3, 4'd2, 0, '0);
        // R6: store by other owner keeps, by owner clears
        apply(1, 3'd2, 26'd3, 4'd1, 0, '0);
        apply(1, 3'd4, 26'd3, 4'd2, 0, '0);
        // R2: reads and reserved kind keep
        apply(1, 3'd5, 26'd5, 4'd0, 0, '0);
        apply(1, 3'd0, 26'd5, 4'd0, 0, '0);
        apply(1, 3'd7, 26'd5, 4'd0, 0, '0);
        // R7: drop other line, then matching
        apply(0, 3'd0, 26'd0, 4'd0, 1, 26'd6);
        apply(0, 3'd0, 26'd0, 4'd0, 1, 26'd5);
        // R8: drop and SC same line
        apply(1, 3'd5, 26'd4, 4'd3, 0, '0);
        apply(1, 3'd6, 26'd4, 4'd3, 1, 26'd4);
        // R9: drop and LL same line
        apply(1, 3'd5, 26'd7, 4'd3, 1, 26'd7);

        // constrained random
        void'($urandom(32'd1234));
        for (int i = 0; i < 2000; i++) begin
            logic dv, pv;
            logic [2:0] k;
            dv = ($urandom % 4) != 0;
            pv = ($urandom % 4) == 0;
            k  = 3'($urandom % 8);
            apply(dv, k, 26'($urandom % 4), 4'($urandom % 3), pv, 26'($urandom % 4));
        end
        done_valid = 0; drop_valid = 0;
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule